// File: doc/BRIEF.md
# Gated Add/Subtract Unit with Status Flags

A combinational two-operand arithmetic unit of parameterised width. A single mode bit picks addition or subtraction. The one-bit carry input is an incoming carry when adding and an incoming borrow when subtracting. The carry output follows the same rule: it is a carry when adding and a borrow when subtracting. Multi-word arithmetic can therefore chain several units through these pins whichever way the operation runs.

Beside the result, the unit reports three status flags:
- signed overflow,
- a negative flag, which is the result's top bit,
- a zero flag.

A whole-unit enable gates everything. While it is low, the result, the carry/borrow output and all flags sit at zero, so the unit can share a result bus through an OR tree with other datapath units.

Top module: `addsub_unit`

## Requirements
- R1: With en_i=1 and sub_i=0 (add mode), {cout_o, f_o} equals a_i + b_i + cin_i as a W+1-bit unsigned sum.
- R2: With en_i=1 and sub_i=1 (subtract mode), f_o equals (a_i - b_i - cin_i) modulo 2^W, where cin_i acts as a borrow-in.
- R3: In subtract mode with en_i=1, cout_o is a borrow-out. It is 1 exactly when a_i < b_i + cin_i as unsigned values, and 0 otherwise.
- R4: With en_i=1, ovf_o is 1 exactly when the operation's true result falls outside the W-bit two's-complement range. The operands are read as signed, and the result is a_i + b_i + cin_i in add mode or a_i - b_i - cin_i in subtract mode.
- R5: With en_i=1, neg_o equals f_o[W-1].
- R6: With en_i=1, zero_o is 1 exactly when every bit of f_o is 0.
- R7: With en_i=0, f_o, cout_o, ovf_o, neg_o and zero_o are all 0 for any operands, mode and carry input.
- R8: R1 through R7 hold for any width W ≥ 2. The default width is 32, and the behaviour also applies at a width of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand |
| b_i | input | W | Second operand (subtrahend in subtract mode) |
| sub_i | input | 1 | Mode: 0 add, 1 subtract |
| cin_i | input | 1 | Carry-in (add) or borrow-in (subtract) |
| en_i | input | 1 | Unit enable; 0 forces all outputs to 0 |
| f_o | output | W | Result |
| cout_o | output | 1 | Carry-out (add) or borrow-out (subtract) |
| ovf_o | output | 1 | Signed overflow |
| neg_o | output | 1 | Result is negative as a signed value |
| zero_o | output | 1 | Result is all zeros |

## Verification
On every change of its inputs, the bound checker recomputes, in wide arithmetic, the sum, the difference, the borrow and the signed range. It compares these with the carry chain's outputs, and it also confirms that disabling the unit forces every output to zero. Some points only the bench's directed and exhaustive scenarios can show:
- the exact carry-chain boundaries, such as the all-ones operand plus a carry and the most-negative value minus one;
- borrow-in turning an equal-operand difference into all ones;
- that the same behaviour holds at a 4-bit width, where every input combination is driven.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } addsub_mode_e;
endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
  import addsub_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]  b_i,
  input  logic          cin_i,
  input  addsub_mode_e  mode_i,
  output logic [W-1:0]  b_eff_o,
  output logic          c_eff_o
);
  // subtract as a + ~b + ~borrow
  always_comb begin
    if (mode_i == MODE_SUB) begin
      b_eff_o = ~b_i;
      c_eff_o = ~cin_i;
    end else begin
      b_eff_o = b_i;
      c_eff_o = cin_i;
    end
  end
endmodule

// File: rtl/addsub_carry_chain.sv
module addsub_carry_chain #(
  parameter int unsigned W          = 32,
  parameter bit          USE_RIPPLE = 1'b1
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         c_o
);
  if (USE_RIPPLE) begin : g_ripple
    logic [W:0] carry;
    assign carry[0] = c_i;
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic p;
      assign p            = x_i[i] ^ y_i[i];
      assign sum_o[i]     = p ^ carry[i];
      assign carry[i+1]   = (x_i[i] & y_i[i]) | (p & carry[i]);
    end
    assign c_o = carry[W];
  end else begin : g_infer
    assign {c_o, sum_o} = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, c_i};
  end
endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit #(
  parameter int unsigned W = 32
) (
  input  logic         en_i,
  input  logic         x_msb_i,
  input  logic         y_msb_i,
  input  logic [W-1:0] sum_i,
  output logic         ovf_o,
  output logic         neg_o,
  output logic         zero_o
);
  logic same_sign;
  logic sign_flip;

  assign same_sign = ~(x_msb_i ^ y_msb_i);
  assign sign_flip = sum_i[W-1] ^ x_msb_i;

  assign ovf_o  = en_i & same_sign & sign_flip;
  assign neg_o  = en_i & sum_i[W-1];
  assign zero_o = en_i & ~(|sum_i);
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int unsigned W          = 32,
  parameter bit          USE_RIPPLE = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  input  logic         en_i,
  output logic [W-1:0] f_o,
  output logic         cout_o,
  output logic         ovf_o,
  output logic         neg_o,
  output logic         zero_o
);
  addsub_mode_e mode;
  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W-1:0] sum;
  logic         c_raw;

  assign mode = addsub_mode_e'(sub_i);

  addsub_operand_prep #(.W(W)) u_prep (
    .b_i    (b_i),
    .cin_i  (cin_i),
    .mode_i (mode),
    .b_eff_o(b_eff),
    .c_eff_o(c_eff)
  );

  addsub_carry_chain #(.W(W), .USE_RIPPLE(USE_RIPPLE)) u_chain (
    .x_i  (a_i),
    .y_i  (b_eff),
    .c_i  (c_eff),
    .sum_o(sum),
    .c_o  (c_raw)
  );

  addsub_flag_unit #(.W(W)) u_flags (
    .en_i   (en_i),
    .x_msb_i(a_i[W-1]),
    .y_msb_i(b_eff[W-1]),
    .sum_i  (sum),
    .ovf_o  (ovf_o),
    .neg_o  (neg_o),
    .zero_o (zero_o)
  );

  // borrow-out is the inverted chain carry
  assign f_o    = en_i ? sum : '0;
  assign cout_o = en_i & ((mode == MODE_SUB) ? ~c_raw : c_raw);
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
  parameter int unsigned W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         sub_i,
  input logic         cin_i,
  input logic         en_i,
  input logic [W-1:0] f_o,
  input logic         cout_o,
  input logic         ovf_o,
  input logic         neg_o,
  input logic         zero_o
);
  logic [W:0] add_wide;
  logic [W:0] sub_wide;
  logic [W:0] sres;
  logic       borrow_ref;
  logic       ovf_ref;

  always_comb begin
    add_wide   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sub_wide   = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
    borrow_ref = ({1'b0, a_i} < ({1'b0, b_i} + {{W{1'b0}}, cin_i}));
    if (sub_i) sres = {a_i[W-1], a_i} - {b_i[W-1], b_i} - {{W{1'b0}}, cin_i};
    else       sres = {a_i[W-1], a_i} + {b_i[W-1], b_i} + {{W{1'b0}}, cin_i};
    ovf_ref    = sres[W] ^ sres[W-1];
  end

  always_comb begin
    if (en_i && !sub_i) begin
      p_add_sum_r1: assert ({cout_o, f_o} == add_wide);
    end
    if (en_i && sub_i) begin
      p_sub_diff_r2: assert (f_o == sub_wide[W-1:0]);
      p_borrow_out_r3: assert (cout_o == borrow_ref);
    end
    if (en_i) begin
      p_overflow_r4: assert (ovf_o == ovf_ref);
      p_negative_r5: assert (neg_o == f_o[W-1]);
      p_zero_r6: assert (zero_o == (f_o == '0));
    end else begin
      p_disabled_quiet_r7: assert (f_o == '0 && !cout_o && !ovf_o && !neg_o && !zero_o);
    end
  end
endmodule

bind addsub_unit addsub_unit_chk #(.W(W)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .sub_i (sub_i),
  .cin_i (cin_i),
  .en_i  (en_i),
  .f_o   (f_o),
  .cout_o(cout_o),
  .ovf_o (ovf_o),
  .neg_o (neg_o),
  .zero_o(zero_o)
);

// File: tb/addsub_unit_tb_top.sv
module addsub_unit_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] a32, b32, f32;
  logic        sub32, cin32, en32, cout32, ovf32, neg32, zero32;
  logic [3:0]  a4, b4, f4;
  logic        sub4, cin4, en4, cout4, ovf4, neg4, zero4;

  addsub_unit #(.W(32)) dut_i (
    .a_i(a32), .b_i(b32), .sub_i(sub32), .cin_i(cin32), .en_i(en32),
    .f_o(f32), .cout_o(cout32), .ovf_o(ovf32), .neg_o(neg32), .zero_o(zero32)
  );

  addsub_unit #(.W(4)) dut_w4_i (
    .a_i(a4), .b_i(b4), .sub_i(sub4), .cin_i(cin4), .en_i(en4),
    .f_o(f4), .cout_o(cout4), .ovf_o(ovf4), .neg_o(neg4), .zero_o(zero4)
  );

  typedef struct {
    bit          narrow;
    logic [31:0] f;
    logic        cout, ovf, neg, zero;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic exp_t model(int w, longint a, longint b, bit sub, bit cin,
                                 bit en, string req);
    exp_t e;
    longint lim, sa, sb, r, d;
    lim = longint'(1) << w;
    e.req = req;
    e.f = '0; e.cout = 0; e.ovf = 0; e.neg = 0; e.zero = 0;
    if (!en) return e;
    sa = (a >= lim / 2) ? a - lim : a;
    sb = (b >= lim / 2) ? b - lim : b;
    if (!sub) begin
      d = a + b + longint'(cin);
      e.cout = (d >= lim);
      r = sa + sb + longint'(cin);
    end else begin
      d = a - b - longint'(cin);
      e.cout = (d < 0);
      r = sa - sb - longint'(cin);
    end
    d = ((d % lim) + lim) % lim;
    e.f    = 32'(d);
    e.ovf  = (r >= lim / 2) || (r < -(lim / 2));
    e.neg  = (d >= lim / 2);
    e.zero = (d == 0);
    return e;
  endfunction

  task automatic drive(bit narrow, logic [31:0] a, logic [31:0] b, bit sub,
                       bit cin, bit en, string req);
    exp_t e;
    @(negedge clk);
    if (narrow) begin
      a4 = a[3:0]; b4 = b[3:0]; sub4 = sub; cin4 = cin; en4 = en;
      e = model(4, longint'(a[3:0]), longint'(b[3:0]), sub, cin, en, req);
    end else begin
      a32 = a; b32 = b; sub32 = sub; cin32 = cin; en32 = en;
      e = model(32, longint'(a), longint'(b), sub, cin, en, req);
    end
    e.narrow = narrow;
    q.push_back(e);
  endtask

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: one item per rising edge, inputs were applied at the prior falling edge
  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.narrow) begin
        cmp(e.req, "f", {28'b0, f4}, e.f);
        cmp(e.req, "cout", {31'b0, cout4}, {31'b0, e.cout});
        cmp(e.req, "ovf", {31'b0, ovf4}, {31'b0, e.ovf});
        cmp(e.req, "neg", {31'b0, neg4}, {31'b0, e.neg});
        cmp(e.req, "zero", {31'b0, zero4}, {31'b0, e.zero});
      end else begin
        cmp(e.req, "f", f32, e.f);
        cmp(e.req, "cout", {31'b0, cout32}, {31'b0, e.cout});
        cmp(e.req, "ovf", {31'b0, ovf32}, {31'b0, e.ovf});
        cmp(e.req, "neg", {31'b0, neg32}, {31'b0, e.neg});
        cmp(e.req, "zero", {31'b0, zero32}, {31'b0, e.zero});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    a32 = '0; b32 = '0; sub32 = 0; cin32 = 0; en32 = 0;
    a4 = '0; b4 = '0; sub4 = 0; cin4 = 0; en4 = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // reset-state and disabled outputs, R7
    drive(0, 32'h0, 32'h0, 0, 0, 0, "R7");
    drive(0, 32'hFFFF_FFFF, 32'h1, 0, 1, 0, "R7");
    drive(0, 32'h8000_0000, 32'h1, 1, 1, 0, "R7");
    drive(1, 32'hF, 32'hF, 0, 1, 0, "R7");

    // add corners, R1 R4 R6
    drive(0, 32'hFFFF_FFFF, 32'h0, 0, 1, 1, "R1");
    drive(0, 32'h7FFF_FFFF, 32'h1, 0, 0, 1, "R4");
    drive(0, 32'h8000_0000, 32'h8000_0000, 0, 0, 1, "R4");
    drive(0, 32'h0, 32'h0, 0, 0, 1, "R6");
    drive(0, 32'h1234_5678, 32'h0FED_CBA8, 0, 1, 1, "R1");

    // subtract corners, R2 R3 R4 R5
    drive(0, 32'h5, 32'h5, 1, 0, 1, "R6");
    drive(0, 32'h5, 32'h5, 1, 1, 1, "R3");
    drive(0, 32'h8000_0000, 32'h1, 1, 0, 1, "R4");
    drive(0, 32'h0, 32'h1, 1, 0, 1, "R5");
    drive(0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 0, 1, "R4");
    drive(0, 32'hA000_0000, 32'h2000_0000, 1, 1, 1, "R2");

    for (int k = 0; k < 300; k++) begin
      bit s;
      s = k[0];
      drive(0, $urandom, $urandom, s, $urandom_range(0, 1) == 1,
            $urandom_range(0, 7) != 0, s ? "R2" : "R1");
    end

    // every input combination at a width of 4, R8
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          drive(1, 32'(a), 32'(b), m[1], m[0], 1, "R8");
        end
      end
    end

    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule